// File: doc/BRIEF.md
# OTP Burn Sequencer

This block runs the programming flow for an external byte-wide one-time-programmable memory on the programmer side. It reads the image through a single-cycle-latency read port into a source memory. The image memory and the target device share one address output. The block steps the two supply-select lines (raised core supply and program voltage on the combined output-enable pin) and issues timed chip-enable pulses. It then reads the device back to confirm what it wrote.

The flow has three phases. First comes a blind pass that gives every address exactly one program pulse. Second comes a verify pass, which reads each byte with the program voltage removed and, on a mismatch, applies up to `MAX_RETRY` more pulses, reading the byte back after each one. Last comes a final pass that drops the core supply to its normal level and compares every byte with the image. The block finishes with `done` raised, `pass` showing the outcome, and the failing address and retry count latched on failure. Every delay is a clock-cycle count derived from `CLK_MHZ`, and `QUICK` swaps in very short counts for simulation.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `dev_ce_n` and `dev_oe_n` are 1 and `dev_doe`, `vpp_on`, `vcc_hi`, `busy` are 0; after reset `done` and `pass` are 0 too.
- R2: A `start` pulse while idle or done raises `vcc_hi` first. `vpp_on` rises only after `vcc_hi` has been high for at least T_VCS cycles (4 with `QUICK`), and `vpp_on` is never 1 while `vcc_hi` is 0.
- R3: Before any read-back, the block gives every address exactly one program pulse, in ascending address order from 0.
- R4: A program pulse is `dev_ce_n` low with `vpp_on` high for exactly T_PW cycles (6 with `QUICK`). During the pulse, `dev_doe` is 1, `dev_dout` equals the image byte of `mem_addr`, and `mem_addr` is stable. Data has been driven for at least T_SU cycles before `dev_ce_n` falls. The image port returns the byte for `mem_addr` one cycle after the address is presented.
- R5: Verify reads (`dev_ce_n`=0, `dev_oe_n`=0) occur with `vpp_on`=0. A byte that mismatches gets another program pulse followed by another read, up to `MAX_RETRY` retry pulses per address.
- R6: If a byte still mismatches after `MAX_RETRY` retry pulses, the block goes to done with `pass`=0, `fail_addr` set to that address and `fail_tries`=`MAX_RETRY`. Both supplies are switched off and no further pulse is issued.
- R7: After the verify pass, the block reads every address again with `vcc_hi`=0 and `vpp_on`=0, starting at 0. The first mismatch ends the run with `pass`=0, `fail_addr` set to that address and `fail_tries`=0.
- R8: When all final reads match, the block sets `done`=1 and `pass`=1, and the device holds the complete image. `pass` is never 1 without `done`.
- R9: `done`, `pass`, `fail_addr` and `fail_tries` hold their values until the next `start`, which clears them and runs the whole flow again.
- R10: `dev_doe` is 0 whenever `dev_oe_n` is 0. After each read, `dev_ce_n` stays high for T_DF cycles before data is driven again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a programming run |
| mem_addr | output | ADDR_W | Address to image memory and target device |
| img_data | input | DATA_W | Image byte, one cycle after `mem_addr` |
| dev_din | input | DATA_W | Data read from the target device |
| dev_dout | output | DATA_W | Data driven to the target device |
| dev_doe | output | 1 | Enable for the `dev_dout` drivers |
| dev_ce_n | output | 1 | Device chip enable, active low; program pulse when `vpp_on` |
| dev_oe_n | output | 1 | Device output enable (logic level), active low |
| vpp_on | output | 1 | Selects program voltage on the output-enable pin |
| vcc_hi | output | 1 | Selects raised core supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with every byte verified |
| fail_addr | output | ADDR_W | Address that failed |
| fail_tries | output | $clog2(MAX_RETRY+1) | Retry pulses given to the failing address |

## Verification
A wrong phase or address register shows up within one pulse as a program pulse on the wrong address, or as a read during the blind pass. A wrong retry counter shows up at the end of the run as a per-address pulse total different from the number the device model needed. A timer or state error shows up in the pulse and setup widths at the first pulse. A supply-sequencing fault shows up as program voltage without raised supply. It also shows up as final reads taken at the wrong supply, which turns a leaky byte into a pass.

// File: rtl/otp_burn_pkg.sv
`timescale 1ns/1ps
package otp_burn_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VCC_UP,
        S_VPP_UP,
        S_FETCH,
        S_DSETUP,
        S_PULSE,
        S_DHOLD,
        S_VPP_DN,
        S_READ,
        S_FLOAT,
        S_VCC_DN,
        S_DONE
    } burn_state_e;

    typedef enum logic [1:0] {
        PH_BLIND,
        PH_VERIFY,
        PH_FINAL
    } burn_phase_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns_cyc(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned pick(bit quick, int unsigned fast,
                                         int unsigned ns, int unsigned mhz);
        return quick ? fast : ns_cyc(ns, mhz);
    endfunction

    function automatic int unsigned t_vcs(bit q, int unsigned m);  return pick(q, 4, 2000, m);   endfunction
    function automatic int unsigned t_su(bit q, int unsigned m);   return pick(q, 3, 2000, m);   endfunction
    function automatic int unsigned t_pw(bit q, int unsigned m);   return pick(q, 6, 100000, m); endfunction
    function automatic int unsigned t_hold(bit q, int unsigned m); return pick(q, 3, 2000, m);   endfunction
    function automatic int unsigned t_rec(bit q, int unsigned m);  return pick(q, 3, 2000, m);   endfunction
    function automatic int unsigned t_dv(bit q, int unsigned m);   return pick(q, 2, 1000, m);   endfunction
    function automatic int unsigned t_df(bit q, int unsigned m);   return pick(q, 2, 130, m);    endfunction

endpackage

// File: rtl/otp_burn_timer.sv
`timescale 1ns/1ps
module otp_burn_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/otp_burn_rdcmp.sv
`timescale 1ns/1ps
module otp_burn_rdcmp #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] ref_byte,
    output logic          match
);

    logic match_d, match_q;

    always_comb begin
        match_d = match_q;
        if (sample) begin
            match_d = (din == ref_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match_d;
        end
    end

    assign match = match_q;

endmodule

// File: rtl/otp_burn_ctrl.sv
`timescale 1ns/1ps
module otp_burn_ctrl
    import otp_burn_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 8,
    parameter int unsigned MAX_RETRY = 10,
    parameter int unsigned CLK_MHZ   = 200,
    parameter bit          QUICK     = 1'b0,
    parameter int unsigned TW        = 16,
    parameter int unsigned RW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] img_data,
    input  logic          match,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          sample,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] data_out,
    output logic          doe,
    output logic          ce_n,
    output logic          oe_n,
    output logic          vpp_on,
    output logic          vcc_hi,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fail_addr,
    output logic [RW-1:0] fail_tries
);

    localparam int unsigned T_VCS  = t_vcs(QUICK, CLK_MHZ);
    localparam int unsigned T_SU   = t_su(QUICK, CLK_MHZ);
    localparam int unsigned T_PW   = t_pw(QUICK, CLK_MHZ);
    localparam int unsigned T_HOLD = t_hold(QUICK, CLK_MHZ);
    localparam int unsigned T_REC  = t_rec(QUICK, CLK_MHZ);
    localparam int unsigned T_DV   = t_dv(QUICK, CLK_MHZ);
    localparam int unsigned T_DF   = t_df(QUICK, CLK_MHZ);
    localparam int unsigned T_FET  = 2;
    localparam logic [AW-1:0] LAST_A = {AW{1'b1}};
    localparam logic [RW-1:0] TRY_CAP = RW'(MAX_RETRY);

    typedef struct packed {
        burn_state_e   st;
        burn_phase_e   ph;
        logic [AW-1:0] addr;
        logic [RW-1:0] tries;
        logic [DW-1:0] data;
        logic          vcc;
        logic          vpp;
        logic          done;
        logic          pass;
        logic [AW-1:0] faddr;
        logic [RW-1:0] ftries;
    } ctrl_t;

    ctrl_t q, d;
    logic  is_last;

    assign is_last = (q.addr == LAST_A);

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE, S_DONE: begin
                if (start) begin
                    d.st     = S_VCC_UP;
                    d.ph     = PH_BLIND;
                    d.addr   = '0;
                    d.tries  = '0;
                    d.vcc    = 1'b1;
                    d.vpp    = 1'b0;
                    d.done   = 1'b0;
                    d.pass   = 1'b0;
                    d.faddr  = '0;
                    d.ftries = '0;
                end
            end
            S_VCC_UP: begin
                if (tmr_expired) begin
                    d.vpp = 1'b1;
                    d.st  = S_VPP_UP;
                end
            end
            S_VPP_UP: begin
                if (tmr_expired) begin
                    d.st = (q.ph == PH_BLIND) ? S_FETCH : S_DSETUP;
                end
            end
            S_FETCH: begin
                if (tmr_expired) begin
                    d.data = img_data;
                    if (q.ph == PH_BLIND) begin
                        d.st = S_DSETUP;
                    end else if (q.vpp) begin
                        d.vpp = 1'b0;
                        d.st  = S_VPP_DN;
                    end else begin
                        d.st = S_READ;
                    end
                end
            end
            S_DSETUP: begin
                if (tmr_expired) d.st = S_PULSE;
            end
            S_PULSE: begin
                if (tmr_expired) d.st = S_DHOLD;
            end
            S_DHOLD: begin
                if (tmr_expired) begin
                    if (q.ph == PH_BLIND) begin
                        if (is_last) begin
                            d.addr = '0;
                            d.ph   = PH_VERIFY;
                        end else begin
                            d.addr = q.addr + AW'(1);
                        end
                        d.st = S_FETCH;
                    end else begin
                        d.vpp = 1'b0;
                        d.st  = S_VPP_DN;
                    end
                end
            end
            S_VPP_DN: begin
                if (tmr_expired) d.st = S_READ;
            end
            S_READ: begin
                if (tmr_expired) d.st = S_FLOAT;
            end
            S_FLOAT: begin
                if (tmr_expired) begin
                    if (match) begin
                        d.tries = '0;
                        if (!is_last) begin
                            d.addr = q.addr + AW'(1);
                            d.st   = S_FETCH;
                        end else if (q.ph == PH_VERIFY) begin
                            d.ph   = PH_FINAL;
                            d.addr = '0;
                            d.vcc  = 1'b0;
                            d.st   = S_VCC_DN;
                        end else begin
                            d.done = 1'b1;
                            d.pass = 1'b1;
                            d.st   = S_DONE;
                        end
                    end else if ((q.ph == PH_FINAL) || (q.tries == TRY_CAP)) begin
                        d.done   = 1'b1;
                        d.pass   = 1'b0;
                        d.faddr  = q.addr;
                        d.ftries = q.tries;
                        d.vcc    = 1'b0;
                        d.vpp    = 1'b0;
                        d.st     = S_DONE;
                    end else begin
                        d.tries = q.tries + RW'(1);
                        d.vpp   = 1'b1;
                        d.st    = S_VPP_UP;
                    end
                end
            end
            S_VCC_DN: begin
                if (tmr_expired) d.st = S_FETCH;
            end
            default: d.st = S_IDLE;
        endcase
    end

    // dwell time of the state about to be entered, minus the entry cycle
    always_comb begin
        unique case (d.st)
            S_VCC_UP, S_VCC_DN: tmr_val = TW'(T_VCS - 1);
            S_VPP_UP, S_DSETUP: tmr_val = TW'(T_SU - 1);
            S_FETCH:            tmr_val = TW'(T_FET - 1);
            S_PULSE:            tmr_val = TW'(T_PW - 1);
            S_DHOLD:            tmr_val = TW'(T_HOLD - 1);
            S_VPP_DN:           tmr_val = TW'(T_REC - 1);
            S_READ:             tmr_val = TW'(T_DV - 1);
            S_FLOAT:            tmr_val = TW'(T_DF - 1);
            default:            tmr_val = '0;
        endcase
    end

    assign tmr_load = (d.st != q.st);
    assign sample   = (q.st == S_READ) && tmr_expired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= S_IDLE;
            q.ph     <= PH_BLIND;
            q.addr   <= '0;
            q.tries  <= '0;
            q.data   <= '0;
            q.vcc    <= 1'b0;
            q.vpp    <= 1'b0;
            q.done   <= 1'b0;
            q.pass   <= 1'b0;
            q.faddr  <= '0;
            q.ftries <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr   = q.addr;
    assign data_out   = q.data;
    assign doe        = (q.st == S_DSETUP) || (q.st == S_PULSE) || (q.st == S_DHOLD);
    assign ce_n       = !((q.st == S_PULSE) || (q.st == S_READ));
    assign oe_n       = !(q.st == S_READ);
    assign vpp_on     = q.vpp;
    assign vcc_hi     = q.vcc;
    assign busy       = (q.st != S_IDLE) && (q.st != S_DONE);
    assign done       = q.done;
    assign pass       = q.pass;
    assign fail_addr  = q.faddr;
    assign fail_tries = q.ftries;

endmodule

// File: rtl/otp_burn_seq.sv
`timescale 1ns/1ps
module otp_burn_seq #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MAX_RETRY = 10,
    parameter int unsigned CLK_MHZ   = 200,
    parameter bit          QUICK     = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    output logic [ADDR_W-1:0]                mem_addr,
    input  logic [DATA_W-1:0]                img_data,
    input  logic [DATA_W-1:0]                dev_din,
    output logic [DATA_W-1:0]                dev_dout,
    output logic                             dev_doe,
    output logic                             dev_ce_n,
    output logic                             dev_oe_n,
    output logic                             vpp_on,
    output logic                             vcc_hi,
    output logic                             busy,
    output logic                             done,
    output logic                             pass,
    output logic [ADDR_W-1:0]                fail_addr,
    output logic [$clog2(MAX_RETRY+1)-1:0]   fail_tries
);

    localparam int unsigned RW = $clog2(MAX_RETRY + 1);
    localparam int unsigned TW = $clog2(otp_burn_pkg::t_pw(QUICK, CLK_MHZ) + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          sample;
    logic          match;

    otp_burn_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    otp_burn_rdcmp #(.DW(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .din      (dev_din),
        .ref_byte (dev_dout),
        .match    (match)
    );

    otp_burn_ctrl #(
        .AW        (ADDR_W),
        .DW        (DATA_W),
        .MAX_RETRY (MAX_RETRY),
        .CLK_MHZ   (CLK_MHZ),
        .QUICK     (QUICK),
        .TW        (TW),
        .RW        (RW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .img_data    (img_data),
        .match       (match),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .sample      (sample),
        .mem_addr    (mem_addr),
        .data_out    (dev_dout),
        .doe         (dev_doe),
        .ce_n        (dev_ce_n),
        .oe_n        (dev_oe_n),
        .vpp_on      (vpp_on),
        .vcc_hi      (vcc_hi),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .fail_addr   (fail_addr),
        .fail_tries  (fail_tries)
    );

endmodule

// File: rtl/otp_burn_seq_chk.sv
`timescale 1ns/1ps
module otp_burn_seq_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned CLK_MHZ = 200,
    parameter bit          QUICK   = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_doe,
    input logic              dev_ce_n,
    input logic              dev_oe_n,
    input logic              vpp_on,
    input logic              vcc_hi,
    input logic              busy,
    input logic              done,
    input logic              pass
);

    localparam logic [31:0] C_VCS = 32'(otp_burn_pkg::t_vcs(QUICK, CLK_MHZ));
    localparam logic [31:0] C_SU  = 32'(otp_burn_pkg::t_su(QUICK, CLK_MHZ));
    localparam logic [31:0] C_PW  = 32'(otp_burn_pkg::t_pw(QUICK, CLK_MHZ));

    logic [31:0] lo_cnt, su_cnt, vcc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            su_cnt  <= '0;
            vcc_cnt <= '0;
        end else begin
            lo_cnt  <= dev_ce_n ? 32'd0 : lo_cnt + 32'd1;
            if (!dev_doe)             su_cnt <= '0;
            else if (dev_ce_n)        su_cnt <= su_cnt + 32'd1;
            if (!vcc_hi)              vcc_cnt <= '0;
            else if (vcc_cnt != '1)   vcc_cnt <= vcc_cnt + 32'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_ce_n && dev_oe_n && !dev_doe && !vpp_on && !vcc_hi)); // R1

    AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_on |-> vcc_hi); // R2

    AST_VCC_LEADS_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_on) |-> (vcc_cnt >= C_VCS)); // R2

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dev_ce_n) && $past(vpp_on)) |-> (lo_cnt == C_PW)); // R4

    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dev_ce_n) && vpp_on) |-> (dev_doe && su_cnt >= C_SU)); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ce_n |=> (dev_ce_n || $stable(mem_addr))); // R4

    AST_READ_NO_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> !vpp_on); // R5

    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R9

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> !dev_doe); // R10

endmodule

bind otp_burn_seq otp_burn_seq_chk #(
    .ADDR_W  (ADDR_W),
    .CLK_MHZ (CLK_MHZ),
    .QUICK   (QUICK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_addr (mem_addr),
    .dev_doe  (dev_doe),
    .dev_ce_n (dev_ce_n),
    .dev_oe_n (dev_oe_n),
    .vpp_on   (vpp_on),
    .vcc_hi   (vcc_hi),
    .busy     (busy),
    .done     (done),
    .pass     (pass)
);

// File: tb/otp_burn_seq_test.sv
`timescale 1ns/1ps
module otp_burn_seq_test;

    localparam int AW   = 4;
    localparam int NA   = 16;
    localparam int MAXR = 10;
    localparam int TPW  = 6;
    localparam int TVCS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    img_data = 8'h00;
    logic [7:0]    dev_din;
    logic [7:0]    dev_dout;
    logic          dev_doe, dev_ce_n, dev_oe_n, vpp_on, vcc_hi;
    logic          busy, done, pass;
    logic [AW-1:0] fail_addr;
    logic [3:0]    fail_tries;

    always #2.5 clk = ~clk;

    otp_burn_seq #(.ADDR_W(AW), .DATA_W(8), .MAX_RETRY(MAXR), .CLK_MHZ(200), .QUICK(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr), .img_data(img_data),
        .dev_din(dev_din), .dev_dout(dev_dout), .dev_doe(dev_doe), .dev_ce_n(dev_ce_n),
        .dev_oe_n(dev_oe_n), .vpp_on(vpp_on), .vcc_hi(vcc_hi), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr), .fail_tries(fail_tries)
    );

    // image source and device model
    logic [7:0] img [NA];
    int         need [NA];
    logic [7:0] dev_mem [NA];
    int         pcnt [NA];
    bit         leak_en = 1'b0;
    int         leak_a = 0;
    bit         model_clr = 1'b1;
    int blind_idx, order_err, width_err, data_err, cont_err, lowv_reads, lo_run;
    int vcc_run, lead_err, vpp_err;
    bit reads_seen, prev_ce, prev_oe, prev_vpp;

    always @(posedge clk) img_data <= img[mem_addr];

    assign dev_din = (!dev_ce_n && !dev_oe_n)
                   ? (dev_mem[mem_addr] ^ ((leak_en && (int'(mem_addr) == leak_a) && !vcc_hi) ? 8'h01 : 8'h00))
                   : 8'hFF;

    always @(negedge clk) begin
        if (model_clr) begin
            for (int i = 0; i < NA; i++) begin dev_mem[i] = 8'hFF; pcnt[i] = 0; end
            blind_idx = 0; order_err = 0; width_err = 0; data_err = 0; cont_err = 0;
            lowv_reads = 0; lo_run = 0; vcc_run = 0; lead_err = 0; vpp_err = 0;
            reads_seen = 0; prev_ce = 1; prev_oe = 1; prev_vpp = 0;
        end else begin
            if (!prev_ce && dev_ce_n && prev_vpp) begin
                if (lo_run != TPW) width_err++;
                if (!dev_doe || dev_dout != img[mem_addr]) data_err++;
                pcnt[mem_addr]++;
                if (pcnt[mem_addr] >= need[mem_addr]) dev_mem[mem_addr] = dev_mem[mem_addr] & dev_dout;
                if (!reads_seen) begin
                    if (int'(mem_addr) != blind_idx) order_err++;
                    blind_idx++;
                end
            end
            if (!dev_ce_n) lo_run++; else lo_run = 0;
            if (prev_oe && !dev_oe_n) begin
                reads_seen = 1;
                if (!vcc_hi) lowv_reads++;
            end
            if (!dev_oe_n && dev_doe) cont_err++;
            if (vpp_on && !vcc_hi) vpp_err++;
            if (vpp_on && !prev_vpp && vcc_run < TVCS) lead_err++;
            vcc_run = vcc_hi ? vcc_run + 1 : 0;
            prev_ce = dev_ce_n; prev_oe = dev_oe_n; prev_vpp = vpp_on;
        end
    end

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic fill_image();
        for (int i = 0; i < NA; i++) img[i] = 8'($urandom) & 8'hFE;
    endtask

    task automatic run_case(input string tag, input bit lk_en, input int lk_a);
        int ecnt [NA];
        int ef;
        bit epass;
        int efa, eft, elow;
        ef = -1;
        for (int a = 0; a < NA; a++) ecnt[a] = 1;
        for (int a = 0; a < NA; a++) begin
            if (ef < 0) begin
                if (need[a] - 1 > MAXR) begin ef = a; ecnt[a] = 1 + MAXR; end
                else ecnt[a] = need[a];
            end
        end
        if (ef >= 0)      begin epass = 0; efa = ef;   eft = MAXR; elow = 0; end
        else if (lk_en)   begin epass = 0; efa = lk_a; eft = 0;    elow = lk_a + 1; end
        else              begin epass = 1; efa = 0;    eft = 0;    elow = NA; end
        leak_en = lk_en; leak_a = lk_a;
        model_clr = 1; @(negedge clk); model_clr = 0;
        start = 1; @(negedge clk); start = 0;
        for (int i = 0; i < 30000 && !done; i++) @(negedge clk);
        chk(done, {tag, " R9 done reached"}, done, 1);
        chk(!busy && !vcc_hi && !vpp_on, {tag, " R6 supplies off at end"}, {vcc_hi, vpp_on}, 0);
        chk(pass == epass, {tag, " R8 pass flag"}, pass, epass);
        if (!epass) begin
            chk(int'(fail_addr) == efa, {tag, " R6 R7 fail_addr"}, fail_addr, efa);
            chk(int'(fail_tries) == eft, {tag, " R6 R7 fail_tries"}, fail_tries, eft);
        end
        for (int a = 0; a < NA; a++)
            chk(pcnt[a] == ecnt[a], $sformatf("%s R5 pulses at %0d", tag, a), pcnt[a], ecnt[a]);
        chk(order_err == 0 && blind_idx == NA, {tag, " R3 blind pass order"}, blind_idx, NA);
        chk(width_err == 0, {tag, " R4 pulse width"}, width_err, 0);
        chk(data_err == 0, {tag, " R4 data during pulse"}, data_err, 0);
        chk(vpp_err == 0 && lead_err == 0, {tag, " R2 supply order"}, vpp_err + lead_err, 0);
        chk(cont_err == 0, {tag, " R10 no contention"}, cont_err, 0);
        chk(lowv_reads == elow, {tag, " R7 reads at normal supply"}, lowv_reads, elow);
        if (epass)
            for (int a = 0; a < NA; a++)
                chk(dev_mem[a] == img[a], $sformatf("%s R8 content at %0d", tag, a), dev_mem[a], img[a]);
        repeat (20) @(negedge clk);
        chk(done && pass == epass && (epass || int'(fail_addr) == efa), {tag, " R9 status held"}, done, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NA; i++) begin img[i] = 8'h00; need[i] = 1; end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass, "R1 reset status", {busy, done, pass}, 0);
        chk(dev_ce_n && dev_oe_n && !dev_doe, "R1 reset device pins", {dev_ce_n, dev_oe_n, dev_doe}, 6);
        chk(!vpp_on && !vcc_hi, "R1 reset supplies", {vpp_on, vcc_hi}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!busy && !vcc_hi, "R1 idle without start", busy, 0);

        fill_image();
        run_case("one-pulse", 0, 0);

        fill_image();
        for (int i = 0; i < NA; i++) need[i] = int'($urandom_range(5, 1));
        run_case("random-need", 0, 0);

        fill_image();
        for (int i = 0; i < NA; i++) need[i] = int'($urandom_range(3, 1));
        need[7] = MAXR + 1;
        run_case("ten-retries", 0, 0);

        fill_image();
        for (int i = 0; i < NA; i++) need[i] = int'($urandom_range(3, 1));
        need[5] = MAXR + 2;
        run_case("retry-exhausted", 0, 0);

        fill_image();
        for (int i = 0; i < NA; i++) need[i] = int'($urandom_range(2, 1));
        run_case("final-leak", 1, 9);

        fill_image();
        for (int i = 0; i < NA; i++) need[i] = 1;
        need[0] = MAXR + 2;
        run_case("fail-first", 0, 0);

        fill_image();
        for (int i = 0; i < NA; i++) need[i] = 1;
        need[NA-1] = MAXR + 1;
        run_case("leak-last", 1, NA - 1);

        fill_image();
        for (int i = 0; i < NA; i++) need[i] = int'($urandom_range(4, 1));
        run_case("rerun-pass", 0, 0);

        finish_run();
    end

    initial begin
        #(5.0 * 190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule